// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split High/Low Accumulator

This execution unit serves a 64-bit integer core. It takes a decoded three-operand instruction together with the values of its two source registers. It multiplies the low 32-bit words of the sources, in signed or unsigned form, and folds the product into a 64-bit accumulator. The upper half of the accumulator is the HI register and the lower half is the LO register. The same instruction also returns one half of the new accumulator, sign-extended to 64 bits, for the destination general register.

Each operation is picked by three flags in the instruction. The negate flag changes the sign of the product. The accumulate flag keeps the old accumulator instead of starting from zero. The half flag selects which half goes to the destination register. Together these flags give plain multiply, negated multiply, multiply-add and multiply-subtract.

The product is built by an iterative shift-and-add multiplier. It handles `MUL_BITS` multiplier bits per cycle. A five-state machine moves through the states IDLE, MULT, COMMIT, DONE and FAULT:
- IDLE→MULT on a legal request.
- IDLE→FAULT on an illegal request.
- MULT→MULT while chunks remain.
- MULT→COMMIT after the last chunk.
- COMMIT→DONE, which writes the accumulator.
- DONE→IDLE and FAULT→IDLE.

Top module: `mac_core`

## Requirements
- R1: After reset, `req_ready`=1, `done`=0, `illegal`=0, `rd_we`=0, and `hi_q` and `lo_q` are 0.
- R2: A request is legal only when all of the following hold: bits 31:26 are zero; bits 5:0 are 011000 (signed) or 011001 (unsigned); in the sub-op field (bits 10:6), bit 6 is 1 and bit 10 is 0. Within the sub-op field, bit 7 is the negate flag, bit 8 is the accumulate flag and bit 9 selects HI for the destination (0 selects LO).
- R3: The signed forms multiply the low 32 bits of both sources as two's-complement values into a 64-bit product. Without the accumulate flag, the accumulator becomes the product, or its negation when the negate flag is set.
- R4: The unsigned forms multiply the low 32 bits of both sources as unsigned values. The negate and accumulate flags act on this product in the same way as for the signed forms.
- R5: With the accumulate flag, the new accumulator is the old accumulator {HI,LO} plus the product, or minus it when the negate flag is set. All accumulator arithmetic, negation included, is modulo 2^64.
- R6: In the done cycle, `rd_data` holds the half of the new accumulator chosen by bit 9, sign-extended to 64 bits. This holds for the unsigned forms as well.
- R7: `rd_idx` carries instruction bits 15:11. `rd_we` is high only in the done cycle and only when this index is nonzero. HI and LO are updated even when the index is zero.
- R8: An illegal request is accepted. It causes a one-cycle `illegal` pulse in the next cycle, gives no `done`, and leaves HI and LO unchanged.
- R9: `req_ready` is low from the cycle after an accepted request until the unit returns to IDLE. Requests presented while it is low are ignored.
- R10: `done` is a one-cycle pulse that rises 32/`MUL_BITS`+1 clock edges after the accepting edge. HI and LO change only as `done` rises, and they show the new value in that same cycle.
- R11: Bits 63:32 of both source operands have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (IDLE) |
| req_instr | input | 32 | Instruction word |
| rs_val | input | 64 | First source operand |
| rt_val | input | 64 | Second source operand |
| done | output | 1 | Result cycle pulse |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Sign-extended accumulator half |
| hi_q | output | 32 | HI register (accumulator bits 63:32) |
| lo_q | output | 32 | LO register (accumulator bits 31:0) |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The latency assertion counts edges from every edge at which `req_valid` and `req_ready` are both high. It therefore assumes that each such edge starts exactly one operation, and that no other request is in flight when `done` appears. The stimulus respects this by driving inputs only on falling edges and raising `req_valid` for a single accepting edge. The one exception is a deliberate request presented while `req_ready` is low, which is withdrawn before the unit returns to IDLE. The bench checks that this request changes nothing. Illegal requests are also issued one at a time, so that the half-select and HI/LO stability properties are only ever evaluated on results from decoded legal operations.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int          OP_W       = 32;
    localparam logic [5:0]  FN_SIGNED  = 6'b011000;
    localparam logic [5:0]  FN_UNSIGN  = 6'b011001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MULT,
        ST_COMMIT,
        ST_DONE,
        ST_FAULT
    } mac_state_e;

    typedef struct packed {
        logic       legal;
        logic       is_signed;
        logic       negate;
        logic       accum;
        logic       sel_hi;
        logic [4:0] dest;
    } mac_op_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [31:0] instr,
    output mac_op_t     op
);
    logic [5:0] opcode;
    logic [5:0] func;
    logic [4:0] sub;
    logic       fn_ok;
    logic       sub_ok;

    assign opcode = instr[31:26];
    assign func   = instr[5:0];
    assign sub    = instr[10:6];

    // bit 0 of the sub-op is a fixed marker, bit 4 is reserved zero
    assign fn_ok  = (func == FN_SIGNED) || (func == FN_UNSIGN);
    assign sub_ok = sub[0] && !sub[4];

    always_comb begin
        op           = '0;
        op.legal     = (opcode == 6'd0) && fn_ok && sub_ok;
        op.is_signed = (func == FN_SIGNED);
        op.negate    = sub[1];
        op.accum     = sub[2];
        op.sel_hi    = sub[3];
        op.dest      = instr[15:11];
    end

endmodule

// File: rtl/mac_iter_mul.sv
module mac_iter_mul #(
    parameter int OPW  = 32,
    parameter int STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OPW-1:0]   a_mag,
    input  logic [OPW-1:0]   b_mag,
    output logic [2*OPW-1:0] prod
);
    localparam int PW = 2 * OPW;

    logic [PW-1:0]  mcand_q;
    logic [PW-1:0]  prod_q;
    logic [OPW-1:0] mplier_q;
    logic [PW-1:0]  part;

    generate
        if (STEP == 1) begin : g_bit
            assign part = mplier_q[0] ? mcand_q : '0;
        end else begin : g_chunk
            assign part = mcand_q * PW'(mplier_q[STEP-1:0]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
        end else if (load) begin
            mcand_q  <= PW'(a_mag);
            mplier_q <= b_mag;
            prod_q   <= '0;
        end else if (step) begin
            prod_q   <= prod_q + part;
            mcand_q  <= mcand_q << STEP;
            mplier_q <= mplier_q >> STEP;
        end
    end

    assign prod = prod_q;

endmodule

// File: rtl/mac_core.sv
module mac_core
    import mac_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int MUL_BITS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            done,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic [OP_W-1:0] hi_q,
    output logic [OP_W-1:0] lo_q,
    output logic            illegal
);
    localparam int ACC_W  = 2 * OP_W;
    localparam int NSTEP  = OP_W / MUL_BITS;
    localparam int CNT_W  = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSTEP - 1);

    mac_state_e       state_q, state_d;
    mac_op_t          dec;
    mac_op_t          op_q;
    logic             flip_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mul_load;
    logic             mul_step;
    logic             commit;
    logic [OP_W-1:0]  a_lo, b_lo, a_mag, b_mag;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_new;
    logic [OP_W-1:0]  half;
    logic [XLEN-1:0]  rd_data_q;
    logic             unused_bits;

    assign a_lo = rs_val[OP_W-1:0];
    assign b_lo = rt_val[OP_W-1:0];
    assign unused_bits = ^{rs_val[XLEN-1:OP_W], rt_val[XLEN-1:OP_W], req_instr[25:16]};

    mac_decode u_dec (
        .instr (req_instr),
        .op    (dec)
    );

    // signed forms multiply magnitudes; the sign is restored at commit
    assign a_mag = (dec.is_signed && a_lo[OP_W-1]) ? (~a_lo + 1'b1) : a_lo;
    assign b_mag = (dec.is_signed && b_lo[OP_W-1]) ? (~b_lo + 1'b1) : b_lo;

    mac_iter_mul #(.OPW(OP_W), .STEP(MUL_BITS)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mul_load),
        .step  (mul_step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (prod)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec.legal ? ST_MULT : ST_FAULT;
            ST_MULT:   if (cnt_q == LAST) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        illegal   = 1'b0;
        mul_load  = 1'b0;
        mul_step  = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mul_load  = req_valid && dec.legal;
            end
            ST_MULT:   mul_step = 1'b1;
            ST_COMMIT: commit   = 1'b1;
            ST_DONE:   done     = 1'b1;
            ST_FAULT:  illegal  = 1'b1;
            default: ;
        endcase
    end

    assign rd_we   = done && (op_q.dest != 5'd0);
    assign rd_idx  = op_q.dest;
    assign rd_data = rd_data_q;

    // step counter and captured operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            op_q   <= '0;
            flip_q <= 1'b0;
        end else if (mul_load) begin
            cnt_q  <= '0;
            op_q   <= dec;
            flip_q <= dec.is_signed && (a_lo[OP_W-1] ^ b_lo[OP_W-1]);
        end else if (mul_step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // accumulator update
    assign term    = (flip_q ^ op_q.negate) ? (~prod + 1'b1) : prod;
    assign base    = op_q.accum ? {hi_q, lo_q} : '0;
    assign acc_new = base + term;
    assign half    = op_q.sel_hi ? acc_new[ACC_W-1:OP_W] : acc_new[OP_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            rd_data_q <= '0;
        end else if (commit) begin
            hi_q      <= acc_new[ACC_W-1:OP_W];
            lo_q      <= acc_new[OP_W-1:0];
            rd_data_q <= {{(XLEN-OP_W){half[OP_W-1]}}, half};
        end
    end

endmodule

// File: rtl/mac_core_chk.sv
module mac_core_chk #(
    parameter int XLEN     = 64,
    parameter int MUL_BITS = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            rd_we,
    input logic [4:0]      rd_idx,
    input logic [XLEN-1:0] rd_data,
    input logic [31:0]     hi_q,
    input logic [31:0]     lo_q,
    input logic            illegal
);
    localparam int LAT = 32 / MUL_BITS + 1;

    logic [15:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       since_q <= 16'hFFFF;
        else if (req_valid && req_ready)  since_q <= '0;
        else if (since_q != 16'hFFFF)     since_q <= since_q + 1'b1;
    end

    // R10
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since_q == 16'(LAT));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hilo_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (hi_q == $past(hi_q) && lo_q == $past(lo_q)));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || illegal) |-> !req_ready);

    // R8
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !done ##1 !illegal);

    // R7
    rd_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (done && rd_idx != 5'd0));

    // R6
    sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_data[XLEN-1:32] == {(XLEN-32){rd_data[31]}});

    // R6
    half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_data[31:0] == hi_q || rd_data[31:0] == lo_q));

endmodule

bind mac_core mac_core_chk #(.XLEN(XLEN), .MUL_BITS(MUL_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rd_we     (rd_we),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .illegal   (illegal)
);

// File: tb/mac_core_tb.sv
module mac_core_tb;
    localparam int MUL_BITS = 1;
    localparam int LAT      = 32 / MUL_BITS + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_instr = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic        done, rd_we, illegal;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data;
    logic [31:0] hi_q, lo_q;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [63:0] model  = '0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    mac_core #(.XLEN(64), .MUL_BITS(MUL_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_instr(req_instr), .rs_val(rs_val), .rt_val(rt_val), .done(done),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data), .hi_q(hi_q),
        .lo_q(lo_q), .illegal(illegal)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit uns, bit neg, bit acc, bit hi, logic [4:0] rd);
        return {6'd0, 5'd3, 5'd4, rd, 1'b0, hi, acc, neg, 1'b1, uns ? 6'b011001 : 6'b011000};
    endfunction

    task automatic do_op(string tag, bit uns, bit neg, bit acc, bit hi,
                         logic [63:0] a, logic [63:0] b, logic [4:0] rd, bit poke);
        logic [63:0] p, term, nxt, expd;
        longint      sa, sb;
        int          cyc;
        sa = longint'(int'(a[31:0]));
        sb = longint'(int'(b[31:0]));
        if (uns) p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
        else     p = sa * sb;
        term = neg ? (64'd0 - p) : p;
        nxt  = (acc ? model : 64'd0) + term;
        expd = hi ? {{32{nxt[63]}}, nxt[63:32]} : {{32{nxt[31]}}, nxt[31:0]};
        @(negedge clk);
        req_valid = 1'b1; req_instr = mk(uns, neg, acc, hi, rd);
        rs_val = a; rt_val = b;
        @(posedge clk);
        cyc = 0;
        forever begin
            @(negedge clk);
            if (cyc == 0) req_valid = 1'b0;
            if (poke && cyc == 1) begin
                // R9: request presented while busy must be ignored
                chk("R9 ready low while busy", {63'd0, req_ready}, 64'd0);
                req_valid = 1'b1; req_instr = mk(1'b1, 1'b0, 1'b0, 1'b1, 5'd9);
                rs_val = 64'hFFFF_FFFF; rt_val = 64'hFFFF_FFFF;
            end
            if (poke && cyc == 2) req_valid = 1'b0;
            if (done || cyc > 4 * LAT) break;
            cyc++;
        end
        chk({tag, " R10 latency"}, 64'(cyc), 64'(LAT));
        chk({tag, " R7 rd_we"}, {63'd0, rd_we}, {63'd0, rd != 5'd0});
        chk({tag, " R7 rd_idx"}, {59'd0, rd_idx}, {59'd0, rd});
        chk({tag, " R6 rd_data"}, rd_data, expd);
        chk({tag, " hi"}, {32'd0, hi_q}, {32'd0, nxt[63:32]});
        chk({tag, " lo"}, {32'd0, lo_q}, {32'd0, nxt[31:0]});
        model = nxt;
        @(negedge clk);
        chk({tag, " R10 done single"}, {62'd0, done, req_ready}, 64'd1);
    endtask

    task automatic bad_op(string tag, logic [31:0] instr);
        @(negedge clk);
        req_valid = 1'b1; req_instr = instr;
        rs_val = 64'd12345; rt_val = 64'd678;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 illegal pulse"}, {62'd0, illegal, done}, 64'd2);
        chk({tag, " R8 state kept"}, {hi_q, lo_q}, model);
        @(negedge clk);
        chk({tag, " R8 pulse ends"}, {62'd0, illegal, req_ready}, 64'd1);
        repeat (LAT + 2) @(negedge clk);
        chk({tag, " R8 no result"}, {hi_q, lo_q, 31'd0, done}, {model, 32'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {59'd0, req_ready, done, illegal, rd_we, 1'b0}, 64'h10);
        chk("R1 reset hilo", {hi_q, lo_q}, 64'd0);

        // R3 R11: signed, upper operand bits set to junk
        do_op("R3 R11 smul lo", 1'b0, 1'b0, 1'b0, 1'b0,
              64'hDEAD_BEEF_FFFF_FFFD, 64'h1234_5678_0000_0007, 5'd5, 1'b0);
        // R4 R6: unsigned product, HI half negative after sign extension
        do_op("R4 R6 umul hi", 1'b1, 1'b0, 1'b0, 1'b1,
              64'hFFFF_FFFF, 64'hFFFF_FFFF, 5'd6, 1'b0);
        // R5: signed accumulate into HI
        do_op("R5 sacc hi", 1'b0, 1'b0, 1'b1, 1'b1,
              64'h8000_0000, 64'h8000_0000, 5'd7, 1'b0);
        // R5: unsigned subtract-accumulate into LO
        do_op("R5 usub lo", 1'b1, 1'b1, 1'b1, 1'b0,
              64'h0001_0000, 64'h0003_0000, 5'd8, 1'b0);
        // R3: signed negate
        do_op("R3 sneg lo", 1'b0, 1'b1, 1'b0, 1'b0,
              64'hFFFF_FFF0, 64'd5, 5'd10, 1'b0);
        // R4 R5: unsigned negate wraps modulo 2^64
        do_op("R4 R5 uneg hi", 1'b1, 1'b1, 1'b0, 1'b1,
              64'h9000_0000, 64'h7, 5'd11, 1'b0);
        // R5: unsigned accumulate overflow past 2^64
        do_op("R5 uacc wrap", 1'b1, 1'b0, 1'b1, 1'b1,
              64'hFFFF_FFFF, 64'hFFFF_FFFF, 5'd12, 1'b0);
        // R7: destination zero still updates HI/LO
        do_op("R7 rd zero", 1'b0, 1'b0, 1'b1, 1'b0,
              64'd1000, 64'hFFFF_FFFF_FFFF_FF9C, 5'd0, 1'b0);
        // R9: request during busy ignored
        do_op("R9 busy ignore", 1'b0, 1'b0, 1'b0, 1'b0,
              64'd77, 64'd3, 5'd13, 1'b1);
        @(negedge clk);
        chk("R9 no extra result", {62'd0, done, illegal}, 64'd0);
        chk("R9 hilo kept", {hi_q, lo_q}, model);

        // R2 R8: decode rejects each illegal pattern
        bad_op("R2 marker bit clear", 32'h0000_0000 | (5'b00000 << 6) | 6'b011000);
        bad_op("R2 reserved bit set", 32'h0000_0000 | (5'b10001 << 6) | 6'b011000);
        bad_op("R2 bad function",     32'h0000_0000 | (5'b00001 << 6) | 6'b011010);
        bad_op("R2 bad opcode",       32'h0400_0000 | (5'b00001 << 6) | 6'b011001);

        // R2: legal after illegal still works
        do_op("R2 R6 smsub hi", 1'b0, 1'b1, 1'b1, 1'b1,
              64'h7FFF_FFFF, 64'h7FFF_FFFF, 5'd31, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule